// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card-side bus clock from the system clock. Software sets it through one 16-bit control word that holds an 8-bit divisor and four mode bits. In the divided mode the card clock runs at the system rate divided by twice the divisor plus one. A bypass mode passes the gated system clock straight through. A power-save mode parks the clock low while the command and data shifters both report idle. The block also drives a one-cycle shift strobe on each falling card-clock edge, so the shifters can launch data, and a wide-bus flag that the data path reads.

To change the rate, software first writes zero to stop the clock and then writes the new divisor with the enable bit set. The divisor is captured only when enable goes from low to high. A combinational helper gives software the smallest divisor whose rate does not exceed a requested target. Typical uses are about 200 kHz during card identification, where the bus must stay under 400 kHz, and 25 MHz for transfers.

The sequencer has five states:
- `ST_OFF`: the clock is stopped.
- `ST_LOW`: the low half of a divided period.
- `ST_HIGH`: the high half of a divided period.
- `ST_PARK`: power-save hold, clock low.
- `ST_BYPASS`: the gated system clock passes through.

The transitions are:
- `ST_OFF`→`ST_LOW` on enable without bypass.
- `ST_OFF`→`ST_BYPASS` on enable with bypass.
- `ST_LOW`→`ST_HIGH` when the half period ends.
- `ST_LOW`→`ST_PARK` when the half period ends while power save is on and both paths are idle.
- `ST_PARK`→`ST_HIGH` when either path becomes busy or power save is cleared.
- `ST_HIGH`→`ST_LOW` when the half period ends.
- Any running state→`ST_OFF` when enable drops or the bypass bit changes.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `sd_clk`, `shift_stb` and `wide_bus` are low, and every control field is zero.
- R2: The control word fields sit at fixed positions. Bits [7:0] hold the divisor, bit 8 enable, bit 9 power save, bit 10 bypass and bit 11 wide bus. Bits [15:12] are unused.
- R3: With enable set and bypass clear, `sd_clk` stays high for N+1 system cycles and low for N+1 system cycles, where N is the captured divisor.
- R4: The divisor is captured only when a write sets enable while enable was clear. A write with enable still set leaves the running period unchanged.
- R5: While enable is clear, `sd_clk` stays low.
- R6: In divided mode, `shift_stb` is high for exactly the first system cycle in which `sd_clk` is low after being high.
- R7: With power save set, the clock parks low at the end of a low half whenever `cmd_idle` and `dat_idle` are both high. It resumes with a full high half once either goes low.
- R8: With enable and bypass set, `sd_clk` follows the system clock: high while the system clock is high, low while it is low.
- R9: When the system rate divides exactly by twice the target, `calc_div` equals the quotient minus one.
- R10: Otherwise `calc_div` is the truncated quotient, so the resulting rate never exceeds the target.
- R11: `calc_div` saturates at 255. A target of zero also gives 255.
- R12: `wide_bus` follows bit 11 of the control word from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word value |
| cmd_idle | input | 1 | Command shifter is idle |
| dat_idle | input | 1 | Data shifter is idle |
| sys_hz | input | 32 | System clock rate for the divisor helper |
| tgt_hz | input | 32 | Requested bus rate for the divisor helper |
| calc_div | output | 8 | Divisor computed by the helper |
| sd_clk | output | 1 | Card bus clock |
| shift_stb | output | 1 | Strobe on falling card-clock edges |
| wide_bus | output | 1 | Wide data bus mode flag |

## Verification
The hardest case to reach is the divisor-hold rule. A rewrite while the clock runs must leave the period untouched even though the stored divisor field changes. The stimulus rewrites with a new divisor and enable still set, measures the period, then writes zero and re-enables, and expects the new period only after that. Power-save parking is reached by setting the mode with both idle inputs high. The bench confirms the clock stays low for a long window, then drops `cmd_idle` and times the first resumed half period.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    parameter int DIV_W  = 8;
    parameter int CTRL_W = 16;

    localparam int EN_BIT   = DIV_W;
    localparam int PS_BIT   = DIV_W + 1;
    localparam int BYP_BIT  = DIV_W + 2;
    localparam int WIDE_BIT = DIV_W + 3;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_PARK   = 3'd3,
        ST_BYPASS = 3'd4
    } clk_state_t;

    typedef struct packed {
        logic [CTRL_W-DIV_W-5:0] spare;
        logic                    wide;
        logic                    bypass;
        logic                    psave;
        logic                    en;
        logic [DIV_W-1:0]        div;
    } ctrl_t;
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  act_div
);
    ctrl_t wr_word;
    assign wr_word = ctrl_t'(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            act_div <= '0;
        end else if (wr) begin
            ctrl <= wr_word;
            // divisor is captured only on the enable 0->1 write
            if (wr_word.en && !ctrl.en) begin
                act_div <= wr_word.div;
            end
        end
    end
endmodule

// File: rtl/sdclk_div_calc.sv
module sdclk_div_calc #(
    parameter int HZ_W  = 32,
    parameter int DIV_W = 8
) (
    input  logic [HZ_W-1:0]  sys_hz,
    input  logic [HZ_W-1:0]  tgt_hz,
    output logic [DIV_W-1:0] div_out
);
    localparam int          QW      = HZ_W + 1;
    localparam logic [QW-1:0] DIV_MAX = QW'((1 << DIV_W) - 1);

    logic [QW-1:0] twice;
    logic [QW-1:0] quot;
    logic [QW-1:0] rem;
    logic [QW-1:0] raw;

    always_comb begin
        twice = {tgt_hz, 1'b0};
        quot  = '0;
        rem   = '0;
        raw   = DIV_MAX;
        if (twice != '0) begin
            quot = {1'b0, sys_hz} / twice;
            rem  = {1'b0, sys_hz} % twice;
            raw  = (rem == '0 && quot != '0) ? quot - 1'b1 : quot;
        end
        div_out = (raw > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : raw[DIV_W-1:0];
    end
endmodule

// File: rtl/sdclk_div_fsm.sv
module sdclk_div_fsm
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             psave,
    input  logic             bypass,
    input  logic             bus_idle,
    input  logic [DIV_W-1:0] act_div,
    output clk_state_t       state,
    output logic [DIV_W-1:0] cnt,
    output logic             sd_clk,
    output logic             shift_stb
);
    clk_state_t       nxt;
    logic [DIV_W-1:0] cnt_n;
    logic             stb_n;
    logic             stb_q;
    logic             byp_gate;
    logic             park_req;
    logic             stop_req;

    assign park_req = psave && bus_idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        nxt      = state;
        cnt_n    = cnt;
        stb_n    = 1'b0;
        stop_req = !en || bypass;
        unique case (state)
            ST_OFF: begin
                cnt_n = '0;
                if (en) nxt = bypass ? ST_BYPASS : ST_LOW;
            end
            ST_LOW: begin
                if (stop_req) begin
                    nxt   = ST_OFF;
                    cnt_n = '0;
                end else if (cnt == act_div) begin
                    cnt_n = '0;
                    nxt   = park_req ? ST_PARK : ST_HIGH;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (stop_req) begin
                    nxt   = ST_OFF;
                    cnt_n = '0;
                    stb_n = 1'b1;
                end else if (cnt == act_div) begin
                    nxt   = ST_LOW;
                    cnt_n = '0;
                    stb_n = 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_PARK: begin
                cnt_n = '0;
                if (stop_req)      nxt = ST_OFF;
                else if (!park_req) nxt = ST_HIGH;
            end
            ST_BYPASS: begin
                cnt_n = '0;
                if (!en || !bypass) nxt = ST_OFF;
            end
            default: begin
                nxt   = ST_OFF;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_n;
    end

    // gate enable changes only while clk is low, so the AND below cannot glitch
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_gate <= 1'b0;
        else        byp_gate <= (state == ST_BYPASS) && !park_req;
    end

    assign sd_clk    = (state == ST_HIGH) || (clk && byp_gate);
    assign shift_stb = stb_q || byp_gate;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int HZ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cmd_idle,
    input  logic              dat_idle,
    input  logic [HZ_W-1:0]   sys_hz,
    input  logic [HZ_W-1:0]   tgt_hz,
    output logic [DIV_W-1:0]  calc_div,
    output logic              sd_clk,
    output logic              shift_stb,
    output logic              wide_bus
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] act_div;
    clk_state_t       state;
    logic [DIV_W-1:0] cnt;

    sdclk_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .wdata   (ctrl_wdata),
        .ctrl    (ctrl),
        .act_div (act_div)
    );

    sdclk_div_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .psave     (ctrl.psave),
        .bypass    (ctrl.bypass),
        .bus_idle  (cmd_idle && dat_idle),
        .act_div   (act_div),
        .state     (state),
        .cnt       (cnt),
        .sd_clk    (sd_clk),
        .shift_stb (shift_stb)
    );

    sdclk_div_calc #(.HZ_W(HZ_W), .DIV_W(DIV_W)) u_calc (
        .sys_hz  (sys_hz),
        .tgt_hz  (tgt_hz),
        .div_out (calc_div)
    );

    assign wide_bus = ctrl.wide;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
#(
    parameter int HZ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input ctrl_t             ctrl,
    input logic [DIV_W-1:0]  act_div,
    input clk_state_t        state,
    input logic [DIV_W-1:0]  cnt,
    input logic              sd_clk,
    input logic              shift_stb,
    input logic              wide_bus,
    input logic [HZ_W-1:0]   sys_hz,
    input logic [HZ_W-1:0]   tgt_hz,
    input logic [DIV_W-1:0]  calc_div
);
    logic [2*HZ_W+1:0] lhs;
    logic [2*HZ_W+1:0] rhs;
    assign lhs = (2*HZ_W+2)'(sys_hz);
    assign rhs = (2*HZ_W+2)'(tgt_hz) * 2 * ((2*HZ_W+2)'(calc_div) + 1);

    assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && $past(!ctrl.en)) |-> !sd_clk);

    assert_stb_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && !ctrl.bypass && $past(!ctrl.bypass) && $past(state) != ST_BYPASS)
        |-> (!sd_clk && $past(sd_clk)));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW || state == ST_HIGH) |-> (cnt <= act_div));

    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && $past(ctrl.en)) |-> $stable(act_div));

    assert_wide_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr) |-> (wide_bus == $past(ctrl_wdata[WIDE_BIT])));

    assert_rate_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_hz != '0 && calc_div != '1) |-> (lhs <= rhs));
endmodule

bind sdclk_gen sdclk_gen_chk #(.HZ_W(HZ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl       (ctrl),
    .act_div    (act_div),
    .state      (state),
    .cnt        (cnt),
    .sd_clk     (sd_clk),
    .shift_stb  (shift_stb),
    .wide_bus   (wide_bus),
    .sys_hz     (sys_hz),
    .tgt_hz     (tgt_hz),
    .calc_div   (calc_div)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        cmd_idle = 1'b1;
    logic        dat_idle = 1'b1;
    logic [31:0] sys_hz = '0;
    logic [31:0] tgt_hz = '0;
    logic [7:0]  calc_div;
    logic        sd_clk;
    logic        shift_stb;
    logic        wide_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    exp;
        string req;
    } calc_item_t;
    calc_item_t sb_q[$];

    always #2.5 clk = ~clk;

    sdclk_gen u_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .cmd_idle(cmd_idle), .dat_idle(dat_idle), .sys_hz(sys_hz), .tgt_hz(tgt_hz),
        .calc_div(calc_div), .sd_clk(sd_clk), .shift_stb(shift_stb), .wide_bus(wide_bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [15:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0;
        lo = 0;
        @(negedge clk);
        while (sd_clk !== 1'b0 && guard < 3000) begin @(negedge clk); guard++; end
        while (sd_clk !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
        while (sd_clk === 1'b1 && guard < 3000) begin hi++; @(negedge clk); guard++; end
        while (sd_clk === 1'b0 && guard < 3000) begin lo++; @(negedge clk); guard++; end
    endtask

    // scoreboard driver: apply inputs, push expected result
    task automatic calc_push(input int s, input int t, input int e, input string r);
        calc_item_t it;
        @(negedge clk);
        sys_hz = s;
        tgt_hz = t;
        it.exp = e;
        it.req = r;
        sb_q.push_back(it);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                calc_item_t it;
                it = sb_q.pop_front();
                check(int'(calc_div) == it.exp, it.req, int'(calc_div), it.exp);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int hi;
        int lo;
        int errs;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sd_clk === 1'b0 && shift_stb === 1'b0 && wide_bus === 1'b0, "R1",
              int'({sd_clk, shift_stb, wide_bus}), 0);

        // R2 R3 divisor 3 with enable bit 8
        write_ctrl(16'h0103);
        measure(hi, lo);
        check(hi == 4, "R3 high half div3", hi, 4);
        check(lo == 4, "R2 R3 low half div3", lo, 4);

        // R6 strobe alignment over a window
        errs = 0;
        @(negedge clk);
        prev = sd_clk;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (shift_stb !== (prev && !sd_clk)) errs++;
            prev = sd_clk;
        end
        check(errs == 0, "R6 strobe on falling edge", errs, 0);

        // R4 rewrite while enabled keeps the period
        write_ctrl(16'h0107);
        measure(hi, lo);
        check(hi == 4 && lo == 4, "R4 divisor held while enabled", hi + lo, 8);

        // R5 stop, stays low
        write_ctrl(16'h0000);
        repeat (3) @(negedge clk);
        errs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sd_clk !== 1'b0) errs++;
        end
        check(errs == 0, "R5 clock low while disabled", errs, 0);

        // R4 re-enable captures new divisor
        write_ctrl(16'h0107);
        measure(hi, lo);
        check(hi == 8 && lo == 8, "R4 divisor captured on enable rise", hi + lo, 16);

        // R3 divisor zero
        write_ctrl(16'h0000);
        write_ctrl(16'h0100);
        measure(hi, lo);
        check(hi == 1 && lo == 1, "R3 divisor zero", hi + lo, 2);

        // R12 wide bus bit 11
        write_ctrl(16'h0000);
        write_ctrl(16'h0800);
        check(wide_bus === 1'b1, "R12 wide set", int'(wide_bus), 1);
        write_ctrl(16'h0000);
        check(wide_bus === 1'b0, "R12 wide clear", int'(wide_bus), 0);

        // R7 power save parks while both idle
        cmd_idle = 1'b1;
        dat_idle = 1'b1;
        write_ctrl(16'h0302);
        repeat (20) @(negedge clk);
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sd_clk !== 1'b0) errs++;
        end
        check(errs == 0, "R7 parked low when idle", errs, 0);
        @(negedge clk);
        cmd_idle = 1'b0;
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R7 resumes when busy", hi + lo, 6);
        cmd_idle = 1'b1;

        // R8 bypass follows system clock
        write_ctrl(16'h0000);
        dat_idle = 1'b1;
        write_ctrl(16'h0500);
        repeat (4) @(negedge clk);
        errs = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            #1;
            if (sd_clk !== 1'b1) errs++;
            @(negedge clk);
            #1;
            if (sd_clk !== 1'b0) errs++;
        end
        check(errs == 0, "R8 bypass follows clock", errs, 0);
        write_ctrl(16'h0000);
        repeat (3) @(negedge clk);
        check(sd_clk === 1'b0, "R5 low after bypass stop", int'(sd_clk), 0);

        // divisor helper cases
        calc_push(100000000, 200000,   249, "R9 100M/200k");
        calc_push(100000000, 25000000, 1,   "R9 100M/25M");
        calc_push(48000000,  400000,   59,  "R9 48M/400k");
        calc_push(50000000,  25000000, 0,   "R9 50M/25M");
        calc_push(100000000, 300000,   166, "R10 100M/300k");
        calc_push(33000000,  10000000, 1,   "R10 33M/10M");
        calc_push(100000000, 100000,   255, "R11 clamp");
        calc_push(100000000, 0,        255, "R11 zero target");
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule